// File: doc/BRIEF.md
# Boot-Block Sector Address Generator

This block turns a flash device type and a bank base address into the start address of every sector in that bank. A start strobe walks through the sector indices in order, one per clock. Each beat shows the index and the absolute start address. A lookup strobe does the reverse: it maps an arbitrary bus address to the sector that contains it, one cycle later. Boot-software accelerators and erase sequencers use it to find sector boundaries without a table in memory.

The bank is a 32-bit bus built from two 16-bit devices side by side, so every per-device size is doubled. Three layout families are covered:
- bottom-boot, with small sectors at the low end;
- top-boot, with small sectors at the high end;
- uniform, with a constant 128 KB stride.

An unknown type code is reported as an error and produces no sectors.

Top module: `sect_addr_gen`

## Requirements
- R1: After reset `valid_o`, `err_o` and `oor_o` are low and `count_o` is 0.
- R2: A start strobe accepted at a clock edge makes `valid_o` high from that edge on. `idx_o` shows 0 first and rises by one per clock up to `count_o`-1. `valid_o` then falls.
- R3: `type_i` codes give these sector counts and bank sizes. 0/1: 11 sectors, 1 MB. 2/3: 19 sectors, 2 MB. 4/5: 35 sectors, 4 MB. 6/7: 71 sectors, 8 MB. 8: 64 sectors, 8 MB. 9: 128 sectors, 16 MB. 10: 256 sectors, 32 MB. Codes 11 to 15 are unknown. Even codes 0 to 6 are bottom-boot and odd codes 1 to 7 are top-boot. `count_o` shows the count of the type most recently accepted.
- R4: Bottom-boot types 0, 2 and 4 place the first four sectors at offsets 0x0, 0x8000, 0xC000 and 0x10000 from the base. Sector i≥4 is at i·0x20000−0x60000.
- R5: Top-boot types 1, 3 and 5 place sector i below the last three at i·0x20000. The third-last, second-last and last sectors sit at size−0x10000, size−0xC000 and size−0x8000.
- R6: Type 6 steps by 0x4000 for sectors 0 to 7 and by 0x20000 after that. Type 7 steps by 0x20000 up to sector 63 and by 0x4000 for its final 8 sectors.
- R7: Uniform types 8, 9 and 10 place sector i at base + i·0x20000.
- R8: A lookup strobe with an address in [base, base+size) gives `valid_o` high for exactly one cycle after the accepting edge. In that cycle `idx_o` is the highest sector whose start is ≤ the address, and `saddr_o` is that sector's start.
- R9: A lookup address below the base or at or above base+size raises `oor_o` and gives no `valid_o`. `oor_o` holds until the next accepted strobe.
- R10: A strobe with an unknown type raises `err_o`, makes `count_o` 0 and yields no valid beat. `err_o` holds until the next accepted strobe.
- R11: While a walk is in progress, start and lookup strobes are ignored. When both strobes arrive together, start wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| type_i | input | TW | Device type code |
| base_i | input | AW | Bank base address |
| addr_i | input | AW | Address to classify in lookup |
| start_i | input | 1 | Begin a sector walk |
| lookup_i | input | 1 | Classify `addr_i` |
| valid_o | output | 1 | `idx_o`/`saddr_o` are meaningful |
| idx_o | output | IW | Sector index |
| saddr_o | output | AW | Sector start address |
| count_o | output | IW | Sector count of the latched type |
| err_o | output | 1 | Latched type is unknown |
| oor_o | output | 1 | Last lookup fell outside the bank |

## Verification
Some properties are checked on every cycle. A walk advances its index by exactly one per clock. Addresses strictly rise during a walk. The latched type and base stay frozen while walking. Every valid index stays below the count. `valid_o` never coincides with an error or an out-of-range flag. Only the bench's scenarios can show the exact offsets of each layout family, including the mirrored boot region of the top-boot parts. The same holds for the lookup index at sector edges and one byte past the bank, and for strobes being dropped mid-walk.

// File: rtl/sect_addr_gen.sv
module sect_addr_gen #(
  parameter int AW = 32,
  parameter int TW = 4,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] type_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  input  logic          start_i,
  input  logic          lookup_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] saddr_o,
  output logic [IW-1:0] count_o,
  output logic          err_o,
  output logic          oor_o
);
  localparam logic [31:0] BLK  = 32'h0002_0000;
  localparam logic [31:0] SML  = 32'h0000_4000;
  localparam logic [TW-1:0] NOTYPE = '1;

  function automatic logic [31:0] cnt_of(input logic [TW-1:0] t);
    case (t)
      0, 1:    cnt_of = 32'd11;
      2, 3:    cnt_of = 32'd19;
      4, 5:    cnt_of = 32'd35;
      6, 7:    cnt_of = 32'd71;
      8:       cnt_of = 32'd64;
      9:       cnt_of = 32'd128;
      10:      cnt_of = 32'd256;
      default: cnt_of = 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] size_of(input logic [TW-1:0] t);
    case (t)
      0, 1:    size_of = 32'h0010_0000;
      2, 3:    size_of = 32'h0020_0000;
      4, 5:    size_of = 32'h0040_0000;
      6, 7, 8: size_of = 32'h0080_0000;
      9:       size_of = 32'h0100_0000;
      10:      size_of = 32'h0200_0000;
      default: size_of = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] off_of(input logic [TW-1:0] t, input logic [IW-1:0] ix);
    logic [31:0] i, n, sz;
    i  = 32'(ix);
    n  = cnt_of(t);
    sz = size_of(t);
    case (t)
      0, 2, 4: begin
        if      (i == 0) off_of = 32'h0;
        else if (i == 1) off_of = 32'h8000;
        else if (i == 2) off_of = 32'hC000;
        else if (i == 3) off_of = 32'h1_0000;
        else             off_of = i * BLK - 32'h6_0000;
      end
      1, 3, 5: begin
        if      (i == n - 1) off_of = sz - 32'h8000;
        else if (i == n - 2) off_of = sz - 32'hC000;
        else if (i == n - 3) off_of = sz - 32'h1_0000;
        else                 off_of = i * BLK;
      end
      6:       off_of = (i < 8)  ? i * SML : (i - 7) * BLK;
      7:       off_of = (i < 63) ? i * BLK : 32'h7E_0000 + (i - 63) * SML;
      default: off_of = i * BLK;
    endcase
  endfunction

  function automatic logic [IW-1:0] idx_of(input logic [TW-1:0] t, input logic [31:0] off);
    logic [31:0] n, sz, r;
    n  = cnt_of(t);
    sz = size_of(t);
    case (t)
      0, 2, 4: begin
        if      (off < 32'h8000)   r = 0;
        else if (off < 32'hC000)   r = 1;
        else if (off < 32'h1_0000) r = 2;
        else if (off < 32'h2_0000) r = 3;
        else                       r = (off >> 17) + 3;
      end
      1, 3, 5: begin
        if      (off < sz - 32'h1_0000) r = off >> 17;
        else if (off < sz - 32'hC000)   r = n - 3;
        else if (off < sz - 32'h8000)   r = n - 2;
        else                            r = n - 1;
      end
      6:       r = (off < 32'h2_0000)  ? (off >> 14) : (off >> 17) + 7;
      7:       r = (off < 32'h7E_0000) ? (off >> 17) : 63 + ((off - 32'h7E_0000) >> 14);
      default: r = off >> 17;
    endcase
    idx_of = IW'(r);
  endfunction

  logic [TW-1:0] typ_r;
  logic [AW-1:0] base_r;
  logic [IW-1:0] idx_r;
  logic          walk_r, lk_r, err_r, oor_r;

  logic [IW-1:0] cnt_r;
  logic          in_unk, in_rng, take;
  logic [31:0]   lk_off;

  assign cnt_r  = IW'(cnt_of(typ_r));
  assign in_unk = (cnt_of(type_i) == 0);
  assign lk_off = 32'(addr_i - base_i);
  assign in_rng = (addr_i >= base_i) && (lk_off < size_of(type_i));
  assign take   = !walk_r && (start_i || lookup_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      typ_r  <= NOTYPE;
      base_r <= '0;
      idx_r  <= '0;
      walk_r <= 1'b0;
      lk_r   <= 1'b0;
      err_r  <= 1'b0;
      oor_r  <= 1'b0;
    end else begin
      lk_r <= 1'b0;
      if (walk_r) begin
        if (idx_r == cnt_r - 1'b1) walk_r <= 1'b0;
        else                       idx_r  <= idx_r + 1'b1;
      end else if (take) begin
        typ_r  <= type_i;
        base_r <= base_i;
        err_r  <= in_unk;
        if (start_i) begin
          idx_r  <= '0;
          walk_r <= !in_unk;
          oor_r  <= 1'b0;
        end else begin
          idx_r  <= in_rng ? idx_of(type_i, lk_off) : '0;
          lk_r   <= !in_unk && in_rng;
          oor_r  <= !in_unk && !in_rng;
        end
      end
    end
  end

  assign valid_o = walk_r | lk_r;
  assign idx_o   = idx_r;
  assign saddr_o = base_r + AW'(off_of(typ_r, idx_r));
  assign count_o = cnt_r;
  assign err_o   = err_r;
  assign oor_o   = oor_r;

  assert_walk_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_r && $past(walk_r) |-> idx_r == $past(idx_r) + 1'b1);

  assert_addr_rising_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_r && $past(walk_r) |-> saddr_o > $past(saddr_o));

  assert_idx_in_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> idx_o < count_o);

  assert_oor_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oor_o |-> !valid_o);

  assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o && count_o == '0);

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    walk_r && $past(walk_r) |-> $stable(typ_r) && $stable(base_r));
endmodule

// File: tb/sect_addr_gen_bench.sv
module sect_addr_gen_bench;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  type_i = 0;
  logic [31:0] base_i = 0, addr_i = 0;
  logic        start_i = 0, lookup_i = 0;
  logic        valid_o, err_o, oor_o;
  logic [8:0]  idx_o, count_o;
  logic [31:0] saddr_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sect_addr_gen u_sect_addr_gen (.clk, .rst_n, .type_i, .base_i, .addr_i, .start_i,
    .lookup_i, .valid_o, .idx_o, .saddr_o, .count_o, .err_o, .oor_o);

  function automatic int unsigned r_cnt(int t);
    int unsigned c[11] = '{11, 11, 19, 19, 35, 35, 71, 71, 64, 128, 256};
    return (t >= 0 && t < 11) ? c[t] : 0;
  endfunction

  function automatic int unsigned r_ssz(int t, int unsigned i);
    int unsigned n = r_cnt(t);
    if (t == 0 || t == 2 || t == 4)
      return (i == 0) ? 'h8000 : (i < 3) ? 'h4000 : (i == 3) ? 'h10000 : 'h20000;
    if (t == 1 || t == 3 || t == 5)
      return (i == n-1) ? 'h8000 : (i >= n-3) ? 'h4000 : (i == n-4) ? 'h10000 : 'h20000;
    if (t == 6) return (i < 8) ? 'h4000 : 'h20000;
    if (t == 7) return (i >= 63) ? 'h4000 : 'h20000;
    return 'h20000;
  endfunction

  function automatic int unsigned r_size(int t);
    int unsigned s = 0;
    for (int unsigned j = 0; j < r_cnt(t); j++) s += r_ssz(t, j);
    return s;
  endfunction

  function automatic int unsigned r_off(int t, int unsigned i);
    int unsigned s = 0;
    for (int unsigned j = 0; j < i; j++) s += r_ssz(t, j);
    return s;
  endfunction

  function automatic int r_find(int t, longint off);
    longint s = 0;
    if (off < 0) return -1;
    for (int unsigned j = 0; j < r_cnt(t); j++) begin
      if (off < s + r_ssz(t, j)) return int'(j);
      s += r_ssz(t, j);
    end
    return -1;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic walk(int t, logic [31:0] b, string req);
    int unsigned n = r_cnt(t);
    @(negedge clk); type_i = 4'(t); base_i = b; start_i = 1;
    @(negedge clk); start_i = 0;
    chk("R3", "count", count_o, n);
    for (int unsigned i = 0; i < n; i++) begin
      chk("R2", "valid", valid_o, 1);
      chk("R2", "idx", idx_o, i);
      chk(req, "saddr", saddr_o, b + r_off(t, i));
      @(negedge clk);
    end
    chk("R2", "valid after walk", valid_o, 0);
  endtask

  task automatic look(int t, logic [31:0] b, logic [31:0] a);
    int k = r_find(t, longint'(a) - longint'(b));
    @(negedge clk); type_i = 4'(t); base_i = b; addr_i = a; lookup_i = 1;
    @(negedge clk); lookup_i = 0;
    if (k >= 0) begin
      chk("R8", "lookup valid", valid_o, 1);
      chk("R8", "lookup idx", idx_o, k);
      chk("R8", "lookup saddr", saddr_o, b + r_off(t, k));
      chk("R9", "oor on hit", oor_o, 0);
      @(negedge clk);
      chk("R8", "valid one cycle", valid_o, 0);
    end else begin
      chk("R9", "oor", oor_o, 1);
      chk("R9", "no valid", valid_o, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "valid", valid_o, 0);
    chk("R1", "err", err_o, 0);
    chk("R1", "oor", oor_o, 0);
    chk("R1", "count", count_o, 0);
    rst_n = 1;

    for (int t = 0; t < 11; t++) begin
      b = $urandom & 32'h7FFF_0000;
      walk(t, b, (t == 6 || t == 7) ? "R6" : (t >= 8) ? "R7" : (t % 2 == 0) ? "R4" : "R5");
    end

    for (int t = 11; t < 16; t++) begin
      @(negedge clk); type_i = 4'(t); start_i = 1;
      @(negedge clk); start_i = 0;
      chk("R10", "err", err_o, 1);
      chk("R10", "count", count_o, 0);
      repeat (2) begin chk("R10", "no valid", valid_o, 0); @(negedge clk); end
    end

    for (int t = 0; t < 11; t++) begin
      b = $urandom & 32'h7FFF_FFFC;
      look(t, b, b);
      look(t, b, b + r_size(t) - 1);
      look(t, b, b + r_size(t));
      look(t, b, b - 1);
      look(t, b, b + r_off(t, r_cnt(t) - 3));
      look(t, b, b + r_off(t, 4) - 1);
    end
    repeat (60) begin
      int t = int'($urandom_range(0, 10));
      b = $urandom & 32'h7FFF_FFFF;
      look(t, b, b + $urandom_range(0, r_size(t) + 32'h1000));
    end

    @(negedge clk); type_i = 4'd12; addr_i = 0; lookup_i = 1;
    @(negedge clk); lookup_i = 0;
    chk("R10", "err on lookup", err_o, 1);
    chk("R10", "no valid on lookup", valid_o, 0);

    b = 32'h0100_0000;
    @(negedge clk); type_i = 4'd2; base_i = b; start_i = 1; lookup_i = 1; addr_i = b + 32'h5_0000;
    @(negedge clk); start_i = 0; lookup_i = 0;
    chk("R11", "start wins idx", idx_o, 0);
    @(negedge clk);
    chk("R11", "start wins walking", idx_o, 1);
    type_i = 4'd10; base_i = 32'h0; addr_i = 32'hFFFF_FFF0; lookup_i = 1; start_i = 1;
    @(negedge clk); lookup_i = 0; start_i = 0;
    chk("R11", "idx continues", idx_o, 2);
    chk("R11", "saddr unchanged base", saddr_o, b + r_off(2, 2));
    chk("R11", "no oor mid walk", oor_o, 0);
    chk("R11", "count kept", count_o, 19);
    while (valid_o) @(negedge clk);
    chk("R11", "walk ended", idx_o, 18);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule